// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This block sits beside a processor pipeline and decides, once per cycle, whether the highest pending interrupt level should be taken. It owns the processor status word (PS) and the vector base register. When an interrupt is taken, it produces a one-cycle redirect strobe with the fetch target. It also produces the writes for the saved-PC, saved-PS, double-exception PC and exception-cause registers, and it updates PS on that same clock edge.

Levels above 1 are vectored directly, one vector per level. A level-1 interrupt is not given its own vector. It is folded into the general exception path: it records a fixed cause code and goes to the user, kernel or double exception vector. Which of these it uses depends on the user-mode and exception-mode bits of PS. When relocation is enabled, every target is shifted by the difference between the vector base register and its configured default.

The controller has two named states:
- `ST_READY` evaluates the inputs.
- `ST_REDIRECT` is the single cycle in which the strobe and all writes are presented.

It has two transitions:
- `take`: from `ST_READY` to `ST_REDIRECT`, when an interrupt qualifies.
- `resume`: from `ST_REDIRECT` back to `ST_READY`, unconditionally.

The caller supplies the pending level, already reduced to the highest one.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, PS reads 0x1F when the interrupt option parameter is set (0x10 when it is clear), the vector base reads its default parameter value, and no redirect or register write is asserted.
- R2: An interrupt is taken only when all three conditions hold:
  - the pending level is strictly greater than PS bits [3:0];
  - the pending level is no greater than the configured level count;
  - the AND of that level's source mask, the interrupt-set vector and the interrupt-enable vector is non-zero.

  Otherwise the redirect strobe and all write enables stay low.
- R3: A taken level L ≥ 2 writes the current PC to the saved-PC register selected by L and writes the old PS to the saved-PS register of L. It sets PS bits [3:0] to L and PS bit 4 (exception mode) to 1, and leaves the other PS bits unchanged.
- R4: The static target for level L ≥ 2 is `INTVEC_BASE + (L-2)*VEC_STRIDE`.
- R5: A taken level-1 interrupt writes cause code 4 to the exception cause register.
- R6: A level-1 interrupt taken while PS bit 4 is set targets the double-exception vector. It saves the PC to the double-exception PC register when that register is configured, otherwise to saved-PC slot 1.
- R7: A level-1 interrupt taken while PS bit 4 is clear saves the PC to saved-PC slot 1. It targets the user vector when PS bit 5 is set, otherwise the kernel vector, and it sets PS bit 4.
- R8: With relocation enabled, the target is the static vector, minus the default base, plus the vector base register as it stood in the deciding cycle. The core loads that register through its write port.
- R9: The redirect strobe and all writes appear together in the cycle after the deciding cycle, for exactly one cycle. No new interrupt is taken during that cycle.
- R10: A core write to PS loads the whole word, except when an interrupt is taken in the same cycle; in that case the dispatch update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_level_i | input | 4 | Highest pending interrupt level |
| intset_i | input | NINT | Interrupt-set bit vector |
| intenable_i | input | NINT | Interrupt-enable bit vector |
| level_mask_i | input | (NLEVEL+1)×NINT | Source mask per level |
| pc_i | input | ADDR_W | Current program counter |
| ps_wr_en_i | input | 1 | Core write strobe for PS |
| ps_wr_data_i | input | ADDR_W | Core write data for PS |
| vb_wr_en_i | input | 1 | Core write strobe for the vector base |
| vb_wr_data_i | input | ADDR_W | Core write data for the vector base |
| ps_o | output | ADDR_W | Current PS |
| vecbase_o | output | ADDR_W | Current vector base |
| redirect_o | output | 1 | One-cycle redirect strobe |
| target_o | output | ADDR_W | Redirect target |
| epc_we_o | output | 1 | Saved-PC write enable |
| epc_sel_o | output | 4 | Saved-PC slot (level) |
| eps_we_o | output | 1 | Saved-PS write enable (slot = epc_sel_o) |
| eps_data_o | output | ADDR_W | Saved-PS data |
| depc_we_o | output | 1 | Double-exception PC write enable |
| save_pc_o | output | ADDR_W | PC value for the saved-PC writes |
| cause_we_o | output | 1 | Exception cause write enable |
| cause_o | output | 6 | Exception cause value |

## Verification
The assertions check the following on every cycle:
- the redirect strobe never lasts two cycles;
- no write enable appears without the strobe;
- PS shows exception mode whenever a redirect is presented;
- every redirect came from a level above the previous PS level;
- a level-1 redirect saves its PC to exactly one place.

Only the bench scenarios can show the exact target arithmetic with and without relocation, the choice among the user, kernel and double vectors, the saved PS contents, and the precedence of dispatch over a simultaneous PS write. The bench checks these against a reference model fed with directed corners and seeded random traffic.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

    localparam int LVL_W       = 4;
    localparam int PS_EXCM_BIT = 4;
    localparam int PS_UM_BIT   = 5;
    localparam int CAUSE_W     = 6;
    localparam logic [CAUSE_W-1:0] CAUSE_L1_INT = 6'd4;

    typedef enum logic [0:0] {
        ST_READY    = 1'b0,
        ST_REDIRECT = 1'b1
    } disp_state_e;

    typedef enum logic [1:0] {
        KIND_HIGH   = 2'd0,
        KIND_KERNEL = 2'd1,
        KIND_USER   = 2'd2,
        KIND_DOUBLE = 2'd3
    } vec_kind_e;

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify
    import irq_disp_pkg::*;
#(
    parameter int NINT   = 13,
    parameter int NLEVEL = 6
) (
    input  logic [LVL_W-1:0]             pend_level,
    input  logic [LVL_W-1:0]             cur_level,
    input  logic [NINT-1:0]              intset,
    input  logic [NINT-1:0]              intenable,
    input  logic [NLEVEL:0][NINT-1:0]    level_mask,
    output logic                         take
);
    localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NLEVEL);

    logic [NLEVEL:0] level_hit;
    logic            sel_hit;

    // one active-source detector per level
    for (genvar lv = 0; lv <= NLEVEL; lv++) begin : g_hit
        assign level_hit[lv] = |(level_mask[lv] & intset & intenable);
    end

    always_comb begin
        sel_hit = 1'b0;
        for (int lv = 0; lv <= NLEVEL; lv++) begin
            if (pend_level == LVL_W'(lv)) sel_hit = level_hit[lv];
        end
    end

    assign take = (pend_level > cur_level) && (pend_level <= MAX_LVL) && sel_hit;

endmodule

// File: rtl/irq_vector.sv
module irq_vector
    import irq_disp_pkg::*;
#(
    parameter int                 ADDR_W      = 32,
    parameter bit                 RELOC_VEC   = 1'b1,
    parameter logic [ADDR_W-1:0]  DEF_VECBASE = 'h5fff8400,
    parameter logic [ADDR_W-1:0]  INTVEC_BASE = 'h5fff857c,
    parameter logic [ADDR_W-1:0]  VEC_STRIDE  = 'h20,
    parameter logic [ADDR_W-1:0]  KERNEL_VEC  = 'h5fff861c,
    parameter logic [ADDR_W-1:0]  USER_VEC    = 'h5fff863c,
    parameter logic [ADDR_W-1:0]  DOUBLE_VEC  = 'h5fff865c
) (
    input  vec_kind_e           kind,
    input  logic [LVL_W-1:0]    level,
    input  logic [ADDR_W-1:0]   vecbase,
    output logic [ADDR_W-1:0]   target
);
    logic [ADDR_W-1:0] static_vec;
    logic [ADDR_W-1:0] level_ofs;

    assign level_ofs = (ADDR_W'(level) - ADDR_W'(2)) * VEC_STRIDE;

    always_comb begin
        unique case (kind)
            KIND_HIGH:   static_vec = INTVEC_BASE + level_ofs;
            KIND_KERNEL: static_vec = KERNEL_VEC;
            KIND_USER:   static_vec = USER_VEC;
            KIND_DOUBLE: static_vec = DOUBLE_VEC;
            default:     static_vec = KERNEL_VEC;
        endcase
    end

    if (RELOC_VEC) begin : g_reloc
        assign target = static_vec - DEF_VECBASE + vecbase;
    end else begin : g_fixed
        logic unused_vb;
        assign unused_vb = ^vecbase;
        assign target    = static_vec;
    end

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_disp_pkg::*;
#(
    parameter int                 NINT        = 13,
    parameter int                 NLEVEL      = 6,
    parameter int                 ADDR_W      = 32,
    parameter bit                 HAS_INT_OPT = 1'b1,
    parameter bit                 HAS_DEPC    = 1'b1,
    parameter bit                 RELOC_VEC   = 1'b1,
    parameter logic [ADDR_W-1:0]  DEF_VECBASE = 'h5fff8400,
    parameter logic [ADDR_W-1:0]  INTVEC_BASE = 'h5fff857c,
    parameter logic [ADDR_W-1:0]  VEC_STRIDE  = 'h20,
    parameter logic [ADDR_W-1:0]  KERNEL_VEC  = 'h5fff861c,
    parameter logic [ADDR_W-1:0]  USER_VEC    = 'h5fff863c,
    parameter logic [ADDR_W-1:0]  DOUBLE_VEC  = 'h5fff865c
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [3:0]                  pend_level_i,
    input  logic [NINT-1:0]             intset_i,
    input  logic [NINT-1:0]             intenable_i,
    input  logic [NLEVEL:0][NINT-1:0]   level_mask_i,
    input  logic [ADDR_W-1:0]           pc_i,
    input  logic                        ps_wr_en_i,
    input  logic [ADDR_W-1:0]           ps_wr_data_i,
    input  logic                        vb_wr_en_i,
    input  logic [ADDR_W-1:0]           vb_wr_data_i,
    output logic [ADDR_W-1:0]           ps_o,
    output logic [ADDR_W-1:0]           vecbase_o,
    output logic                        redirect_o,
    output logic [ADDR_W-1:0]           target_o,
    output logic                        epc_we_o,
    output logic [3:0]                  epc_sel_o,
    output logic                        eps_we_o,
    output logic [ADDR_W-1:0]           eps_data_o,
    output logic                        depc_we_o,
    output logic [ADDR_W-1:0]           save_pc_o,
    output logic                        cause_we_o,
    output logic [5:0]                  cause_o
);
    localparam logic [ADDR_W-1:0] PS_RST = HAS_INT_OPT ? ADDR_W'('h1F) : ADDR_W'('h10);

    disp_state_e        state_q, state_d;
    logic [ADDR_W-1:0]  ps_q, ps_d, ps_taken;
    logic [ADDR_W-1:0]  vb_q, vb_d;
    logic               take, fire;
    vec_kind_e          kind;
    logic [ADDR_W-1:0]  vec_target;

    logic               rd_d, epc_we_d, eps_we_d, depc_we_d, cause_we_d;
    logic [LVL_W-1:0]   epc_sel_d;
    logic [ADDR_W-1:0]  tgt_d, eps_d, save_pc_d;
    logic [CAUSE_W-1:0] cause_d;

    irq_qualify #(.NINT(NINT), .NLEVEL(NLEVEL)) u_qual (
        .pend_level (pend_level_i),
        .cur_level  (ps_q[LVL_W-1:0]),
        .intset     (intset_i),
        .intenable  (intenable_i),
        .level_mask (level_mask_i),
        .take       (take)
    );

    irq_vector #(
        .ADDR_W(ADDR_W), .RELOC_VEC(RELOC_VEC), .DEF_VECBASE(DEF_VECBASE),
        .INTVEC_BASE(INTVEC_BASE), .VEC_STRIDE(VEC_STRIDE),
        .KERNEL_VEC(KERNEL_VEC), .USER_VEC(USER_VEC), .DOUBLE_VEC(DOUBLE_VEC)
    ) u_vec (
        .kind    (kind),
        .level   (pend_level_i),
        .vecbase (vb_q),
        .target  (vec_target)
    );

    // vector class of the pending level
    always_comb begin
        if (pend_level_i != LVL_W'(1))     kind = KIND_HIGH;
        else if (ps_q[PS_EXCM_BIT])        kind = KIND_DOUBLE;
        else if (ps_q[PS_UM_BIT])          kind = KIND_USER;
        else                               kind = KIND_KERNEL;
    end

    // next state: take / resume
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_READY: begin
                if (take) begin
                    state_d = ST_REDIRECT;
                    fire    = 1'b1;
                end
            end
            ST_REDIRECT: state_d = ST_READY;
            default:     state_d = ST_READY;
        endcase
    end

    // architectural register updates
    always_comb begin
        ps_taken = ps_q;
        ps_taken[PS_EXCM_BIT] = 1'b1;
        if (kind == KIND_HIGH) ps_taken[LVL_W-1:0] = pend_level_i;

        if (fire)            ps_d = ps_taken;
        else if (ps_wr_en_i) ps_d = ps_wr_data_i;
        else                 ps_d = ps_q;

        vb_d = vb_wr_en_i ? vb_wr_data_i : vb_q;
    end

    // redirect and save-register writes
    always_comb begin
        rd_d       = 1'b0;
        tgt_d      = '0;
        save_pc_d  = '0;
        epc_we_d   = 1'b0;
        epc_sel_d  = '0;
        eps_we_d   = 1'b0;
        eps_d      = '0;
        depc_we_d  = 1'b0;
        cause_we_d = 1'b0;
        cause_d    = '0;
        if (fire) begin
            rd_d      = 1'b1;
            tgt_d     = vec_target;
            save_pc_d = pc_i;
            unique case (kind)
                KIND_HIGH: begin
                    epc_we_d  = 1'b1;
                    epc_sel_d = pend_level_i;
                    eps_we_d  = 1'b1;
                    eps_d     = ps_q;
                end
                KIND_USER, KIND_KERNEL: begin
                    epc_we_d   = 1'b1;
                    epc_sel_d  = LVL_W'(1);
                    cause_we_d = 1'b1;
                    cause_d    = CAUSE_L1_INT;
                end
                KIND_DOUBLE: begin
                    cause_we_d = 1'b1;
                    cause_d    = CAUSE_L1_INT;
                    if (HAS_DEPC) begin
                        depc_we_d = 1'b1;
                    end else begin
                        epc_we_d  = 1'b1;
                        epc_sel_d = LVL_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_READY;
            ps_q       <= PS_RST;
            vb_q       <= DEF_VECBASE;
            redirect_o <= 1'b0;
            target_o   <= '0;
            save_pc_o  <= '0;
            epc_we_o   <= 1'b0;
            epc_sel_o  <= '0;
            eps_we_o   <= 1'b0;
            eps_data_o <= '0;
            depc_we_o  <= 1'b0;
            cause_we_o <= 1'b0;
            cause_o    <= '0;
        end else begin
            state_q    <= state_d;
            ps_q       <= ps_d;
            vb_q       <= vb_d;
            redirect_o <= rd_d;
            target_o   <= tgt_d;
            save_pc_o  <= save_pc_d;
            epc_we_o   <= epc_we_d;
            epc_sel_o  <= epc_sel_d;
            eps_we_o   <= eps_we_d;
            eps_data_o <= eps_d;
            depc_we_o  <= depc_we_d;
            cause_we_o <= cause_we_d;
            cause_o    <= cause_d;
        end
    end

    assign ps_o      = ps_q;
    assign vecbase_o = vb_q;

    // R9
    redirect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);

    // R9
    writes_need_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (epc_we_o || eps_we_o || depc_we_o || cause_we_o) |-> redirect_o);

    // R3
    excm_on_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> ps_o[PS_EXCM_BIT]);

    // R2
    level_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(redirect_o) |-> ($past(pend_level_i) > $past(ps_q[LVL_W-1:0])));

    // R6
    l1_single_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_we_o |-> $onehot({depc_we_o, epc_we_o}));

    // R3
    eps_high_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eps_we_o |-> (epc_we_o && epc_sel_o >= 4'd2));

endmodule

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
    localparam int NINT = 13;
    localparam int NLV  = 6;
    localparam logic [31:0] DEFVB = 32'h5fff8400;
    localparam logic [31:0] IVB   = 32'h5fff857c;
    localparam logic [31:0] KVEC  = 32'h5fff861c;
    localparam logic [31:0] UVEC  = 32'h5fff863c;
    localparam logic [31:0] DVEC  = 32'h5fff865c;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] pend;
    logic [NINT-1:0] iset, ien;
    logic [NLV:0][NINT-1:0] masks;
    logic [31:0] pc, psd, vbd;
    logic pswe, vbwe;
    logic [31:0] ps_o, vb_o, tgt_o, epsd_o, spc_o;
    logic rd_o, epcwe_o, epswe_o, depcwe_o, cwe_o;
    logic [3:0] sel_o;
    logic [5:0] cause_o;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [31:0] m_ps, m_vb;
    logic m_busy;
    logic e_rd, e_epcwe, e_epswe, e_depcwe, e_cwe;
    logic [3:0] e_sel;
    logic [31:0] e_tgt, e_epsd, e_spc;

    always #5 clk = ~clk;

    irq_dispatch uut (
        .clk(clk), .rst_n(rst_n), .pend_level_i(pend), .intset_i(iset),
        .intenable_i(ien), .level_mask_i(masks), .pc_i(pc),
        .ps_wr_en_i(pswe), .ps_wr_data_i(psd), .vb_wr_en_i(vbwe),
        .vb_wr_data_i(vbd), .ps_o(ps_o), .vecbase_o(vb_o),
        .redirect_o(rd_o), .target_o(tgt_o), .epc_we_o(epcwe_o),
        .epc_sel_o(sel_o), .eps_we_o(epswe_o), .eps_data_o(epsd_o),
        .depc_we_o(depcwe_o), .save_pc_o(spc_o), .cause_we_o(cwe_o),
        .cause_o(cause_o)
    );

    task automatic cmp(input string tag, input string fld, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h exp %h", tag, fld, got, exp);
        end
    endtask

    // apply inputs at a negedge, predict the next cycle, then check it
    task automatic cyc(input logic [3:0] pl, input logic [NINT-1:0] st, input logic [NINT-1:0] en,
                       input logic [31:0] p, input logic pw, input logic [31:0] pd,
                       input logic vw, input logic [31:0] vd, input string tag);
        logic fire;
        logic [31:0] base;
        pend = pl; iset = st; ien = en; pc = p; pswe = pw; psd = pd; vbwe = vw; vbd = vd;
        fire = !m_busy && (pl > m_ps[3:0]) && (pl <= 4'(NLV)) && (|(masks[pl[2:0]] & st & en));
        e_rd = fire; e_epcwe = 0; e_epswe = 0; e_depcwe = 0; e_cwe = 0;
        e_sel = 0; e_epsd = 0; e_spc = p; base = 0;
        if (fire) begin
            if (pl != 4'd1) begin
                base = IVB + (32'(pl) - 32'd2) * 32'h20;
                e_epcwe = 1; e_sel = pl; e_epswe = 1; e_epsd = m_ps;
            end else begin
                e_cwe = 1;
                if (m_ps[4]) begin base = DVEC; e_depcwe = 1; end
                else begin base = m_ps[5] ? UVEC : KVEC; e_epcwe = 1; e_sel = 4'd1; end
            end
            e_tgt = base - DEFVB + m_vb;
        end else begin
            e_tgt = 0;
        end
        // model state update
        if (fire) begin
            if (pl != 4'd1) m_ps[3:0] = pl;
            m_ps[4] = 1'b1;
        end else if (pw) begin
            m_ps = pd;
        end
        if (vw) m_vb = vd;
        m_busy = fire;
        @(negedge clk);
        cmp(tag, "redirect", 32'(rd_o), 32'(e_rd));
        cmp(tag, "ps", ps_o, m_ps);
        cmp(tag, "vecbase", vb_o, m_vb);
        cmp(tag, "epc_we", 32'(epcwe_o), 32'(e_epcwe));
        cmp(tag, "eps_we", 32'(epswe_o), 32'(e_epswe));
        cmp(tag, "depc_we", 32'(depcwe_o), 32'(e_depcwe));
        cmp(tag, "cause_we", 32'(cwe_o), 32'(e_cwe));
        if (e_rd) begin
            cmp(tag, "target", tgt_o, e_tgt);
            cmp(tag, "save_pc", spc_o, e_spc);
            if (e_epcwe) cmp(tag, "epc_sel", 32'(sel_o), 32'(e_sel));
            if (e_epswe) cmp(tag, "eps_data", epsd_o, e_epsd);
            if (e_cwe)   cmp(tag, "cause", 32'(cause_o), 32'd4);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NINT-1:0] ALL;
        void'($urandom(32'd4242));
        ALL = '1;
        for (int l = 0; l <= NLV; l++) masks[l] = NINT'((1 << l) | (1 << (l + 6)));
        pend = 0; iset = 0; ien = 0; pc = 0; pswe = 0; psd = 0; vbwe = 0; vbd = 0;
        m_ps = 32'h1F; m_vb = DEFVB; m_busy = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cmp("R1", "ps", ps_o, 32'h1F);
        cmp("R1", "vecbase", vb_o, DEFVB);
        cmp("R1", "redirect", 32'(rd_o), 32'd0);

        cyc(4'd3, ALL, ALL, 32'h100, 0, 0, 0, 0, "R2 blocked by level");
        cyc(4'd0, 0, 0, 32'h104, 1, 32'h0, 0, 0, "R10 ps load");
        cyc(4'd3, ALL, ALL, 32'h1000, 0, 0, 0, 0, "R3 high level take");
        cyc(4'd5, ALL, ALL, 32'h1004, 0, 0, 0, 0, "R9 no take in strobe");
        cyc(4'd5, ALL, ALL, 32'h1008, 0, 0, 0, 0, "R4 level5 vector");
        cyc(4'd0, 0, 0, 32'h0, 1, 32'h20, 0, 0, "R10 ps load um");
        cyc(4'd1, ALL, ALL, 32'h2000, 0, 0, 0, 0, "R5 R7 user vector");
        cyc(4'd0, 0, 0, 32'h0, 0, 0, 0, 0, "R9 idle");
        cyc(4'd1, ALL, ALL, 32'h3000, 0, 0, 0, 0, "R6 double vector");
        cyc(4'd0, 0, 0, 32'h0, 1, 32'h0, 0, 0, "R10 ps clear");
        cyc(4'd1, ALL, ALL, 32'h4000, 0, 0, 0, 0, "R7 kernel vector");
        cyc(4'd0, 0, 0, 32'h0, 1, 32'h0, 1, 32'h40000000, "R8 vecbase load");
        cyc(4'd4, ALL, ALL, 32'h5000, 0, 0, 0, 0, "R8 relocated");
        cyc(4'd0, 0, 0, 32'h0, 1, 32'h0, 0, 0, "R10 ps clear");
        cyc(4'd7, ALL, ALL, 32'h6000, 0, 0, 0, 0, "R2 above max level");
        cyc(4'd2, ~NINT'(13'h104), ALL, 32'h6004, 0, 0, 0, 0, "R2 mask miss");
        cyc(4'd2, ALL, ALL, 32'h7000, 1, 32'h3F, 0, 0, "R10 dispatch wins");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(4'($urandom % 8), NINT'($urandom), NINT'($urandom), $urandom & 32'hFFFF_FFFC,
                (r[3:0] == 4'd0), {$urandom, 4'b0} | 32'($urandom % 4) | ((r[8]) ? 32'h0 : 32'h0),
                (r[9:5] == 5'd0), {4'h6, 28'($urandom)}, "R2 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule